// File: doc/BRIEF.md
# Per-Rank Activate Window Limiter

This block throttles DRAM row activates so that each rank of a channel sees no more than a set number of activates inside any rolling window. The scheduler reports every activate it has issued by pulsing a record strobe with the rank index and the activate's timestamp. For every rank the block keeps the most recent activate times, ordered by age. When a new activate makes the window too crowded, it publishes the earliest time at which that rank may take its next activate.

The published time applies only to activates. It is kept apart from any bank-busy bookkeeping, so reads, writes and other commands to the rank are never held back by it. When the scheduler records an activate that falls too close to the oldest remembered activate of its rank, a one-cycle violation flag is raised. The activate is still logged. A rank index outside the configured range also raises the flag, and that record is otherwise dropped. Setting the activate limit to zero turns the limiter off.

Top module: `act_window_limiter`

## Requirements
- R1: Recording an activate changes only the history and allowed time of the addressed rank. The other ranks' `allow_at` fields keep their values. Rank r owns bits [r*TS_W +: TS_W] of `allow_at`.
- R2: Each rank remembers its last ACT_LIMIT activate times. A record drops the oldest entry and stores the new timestamp as the newest entry.
- R3: After the insert, let the new oldest entry be E. If E is nonzero and (timestamp − E) modulo 2^TS_W is less than WINDOW, that rank's allowed time becomes E + WINDOW.
- R4: If the R3 condition is false, the rank's allowed time keeps its previous value.
- R5: `viol` is high for one cycle, in the cycle after a record to a valid rank, when the pre-insert oldest entry is nonzero and lies less than WINDOW before the new timestamp. That record is still stored.
- R6: A zero history entry counts as empty. It never raises `viol` and never sets an allowed time.
- R7: Reset clears every history entry, every allowed time and `viol` to zero.
- R8: A record whose rank index is NUM_RANKS or larger changes no state and sets `viol` in the following cycle.
- R9: With ACT_LIMIT = 0, records change nothing. `allow_at` stays zero, and `viol` rises only for out-of-range ranks.
- R10: An allowed time updated by a record is visible on `allow_at` in the cycle after the record strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record-activate strobe |
| rec_rank | input | RANK_W | Rank of the recorded activate |
| rec_time | input | TS_W | Timestamp of the recorded activate |
| allow_at | output | NUM_RANKS*TS_W | Earliest next activate time, one field per rank |
| viol | output | 1 | Window-violation pulse for the previous record |

## Verification
The bench uses several activate patterns on rank 0:
- A tight burst, which must set an allowed time only once the history is full.
- One further close activate, which must both flag a violation and move the allowed time.
- A late activate, which must leave the allowed time alone.

Rank 2 receives widely spaced activates, which separate the window test from plain history filling. Rank 1 starts with activates at timestamp zero, to confirm that empty entries never enforce the window. Interleaving the ranks checks isolation. A rank index beyond the configured range is applied to both the enabled instance and a second instance with the limit disabled.

// File: rtl/actlim_pkg.sv
package actlim_pkg;
  localparam int TS_MAX_W = 32;

  // age is the modular distance from a stored entry to the new timestamp
  function automatic logic window_hit(input logic [TS_MAX_W-1:0] age,
                                      input logic                 occupied,
                                      input logic [TS_MAX_W-1:0] win);
    return occupied && (age < win);
  endfunction
endpackage

// File: rtl/actlim_rank.sv
module actlim_rank #(
  parameter int ACT_LIMIT = 4,
  parameter int TS_W      = 16,
  parameter int WINDOW    = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [TS_W-1:0] t,
  output logic            early_hit,
  output logic [TS_W-1:0] allow_q
);
  import actlim_pkg::*;

  localparam logic [TS_W-1:0] WIN = TS_W'(WINDOW);

  logic [TS_W-1:0] hist [ACT_LIMIT];
  logic [TS_W-1:0] post_old;
  logic [TS_W-1:0] age_pre, age_post;
  logic            late_hit;

  generate
    if (ACT_LIMIT == 1) begin : g_single
      assign post_old = t;
    end else begin : g_multi
      assign post_old = hist[ACT_LIMIT-2];
    end
  endgenerate

  always_comb begin
    age_pre   = t - hist[ACT_LIMIT-1];
    age_post  = t - post_old;
    early_hit = window_hit(TS_MAX_W'(age_pre), hist[ACT_LIMIT-1] != '0, TS_MAX_W'(WIN));
    late_hit  = window_hit(TS_MAX_W'(age_post), post_old != '0, TS_MAX_W'(WIN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ACT_LIMIT; k++) hist[k] <= '0;
      allow_q <= '0;
    end else if (wr) begin
      hist[0] <= t;
      for (int k = 1; k < ACT_LIMIT; k++) hist[k] <= hist[k-1];
      if (late_hit) allow_q <= post_old + WIN;
    end
  end

  // R1: no record for this rank, no movement of its allowed time
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(allow_q));

  // R3: a new allowed time lies after the triggering timestamp, within one window
  assert_enforce_bound_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(allow_q) |-> ((allow_q - $past(t)) <= WIN) && (allow_q != $past(t)));
endmodule

// File: rtl/actlim_flag.sv
module actlim_flag (
  input  logic clk,
  input  logic rst,
  input  logic rec_valid,
  input  logic rank_bad,
  input  logic hit,
  output logic viol_q
);
  always_ff @(posedge clk) begin
    if (rst) viol_q <= 1'b0;
    else     viol_q <= rec_valid && (rank_bad || hit);
  end

  // R5: a violation pulse always follows a record strobe
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (rst)
    viol_q |-> $past(rec_valid));

  // R8: an out-of-range rank is always flagged
  assert_bad_rank_R8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rank_bad) |=> viol_q);
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int NUM_RANKS = 3,
  parameter int ACT_LIMIT = 4,
  parameter int WINDOW    = 20,
  parameter int TS_W      = 16,
  parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rec_valid,
  input  logic [RANK_W-1:0]         rec_rank,
  input  logic [TS_W-1:0]           rec_time,
  output logic [NUM_RANKS*TS_W-1:0] allow_at,
  output logic                      viol
);
  logic [NUM_RANKS-1:0] rank_sel;
  logic [NUM_RANKS-1:0] rank_hit;
  logic                 rank_bad;
  logic                 any_hit;

  generate
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_sel
      assign rank_sel[r] = rec_valid && (rec_rank == RANK_W'(r));
    end
  endgenerate

  assign rank_bad = rec_valid && (rank_sel == '0);
  assign any_hit  = |(rank_sel & rank_hit);

  generate
    if (ACT_LIMIT == 0) begin : g_off
      assign rank_hit = '0;
      assign allow_at = '0;
    end else begin : g_on
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        actlim_rank #(
          .ACT_LIMIT(ACT_LIMIT),
          .TS_W     (TS_W),
          .WINDOW   (WINDOW)
        ) u_rank (
          .clk      (clk),
          .rst      (rst),
          .wr       (rank_sel[r]),
          .t        (rec_time),
          .early_hit(rank_hit[r]),
          .allow_q  (allow_at[r*TS_W +: TS_W])
        );
      end
    end
  endgenerate

  actlim_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .rec_valid(rec_valid),
    .rank_bad (rank_bad),
    .hit      (any_hit),
    .viol_q   (viol)
  );

  // R7: the cycle after reset, every allowed time reads zero
  assert_reset_clear_R7: assert property (@(posedge clk)
    $past(rst) |-> (allow_at == '0) && !viol);

  // R8: an out-of-range record leaves every allowed time untouched
  assert_bad_rank_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rank_bad && !$past(rst)) |=> $stable(allow_at));
endmodule

// File: tb/test_act_window_limiter.sv
module test_act_window_limiter;
  localparam int N = 3, X = 4, W = 20, TW = 16, RW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rec_valid = 1'b0;
  logic [RW-1:0] rec_rank = '0;
  logic [TW-1:0] rec_time = '0;
  logic [N*TW-1:0] allow_at, allow_off;
  logic          viol, viol_off;

  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  act_window_limiter #(.NUM_RANKS(N), .ACT_LIMIT(X), .WINDOW(W), .TS_W(TW)) i_act_window_limiter (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_rank(rec_rank),
    .rec_time(rec_time), .allow_at(allow_at), .viol(viol));

  act_window_limiter #(.NUM_RANKS(N), .ACT_LIMIT(0), .WINDOW(W), .TS_W(TW)) i_act_window_limiter_off (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_rank(rec_rank),
    .rec_time(rec_time), .allow_at(allow_off), .viol(viol_off));

  // reference model
  logic [TW-1:0] m_hist [N][X];
  logic [TW-1:0] m_allow [N];

  // scoreboard queues
  logic [N*TW-1:0] q_allow [$];
  bit              q_viol [$];
  bit              q_voff [$];
  string           q_req [$];

  task automatic step(input bit v, input int r, input int t, input string req);
    logic [TW-1:0] ts, age, old;
    logic [N*TW-1:0] exp_allow;
    bit ev, evoff;
    @(negedge clk);
    ts = TW'(t);
    rec_valid = v; rec_rank = RW'(r); rec_time = ts;
    ev = 1'b0; evoff = 1'b0;
    if (v) begin
      if (r < N) begin
        old = m_hist[r][X-1];
        age = ts - old;
        ev = (old != 0) && (age < TW'(W));
        for (int k = X-1; k > 0; k--) m_hist[r][k] = m_hist[r][k-1];
        m_hist[r][0] = ts;
        old = m_hist[r][X-1];
        age = ts - old;
        if ((old != 0) && (age < TW'(W))) m_allow[r] = old + TW'(W);
      end else begin
        ev = 1'b1; evoff = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) exp_allow[i*TW +: TW] = m_allow[i];
    q_allow.push_back(exp_allow); q_viol.push_back(ev);
    q_voff.push_back(evoff); q_req.push_back(req);
  endtask

  // monitor: samples 2 ns after the edge that consumed each driven item
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q_req.size() > 0) begin
        logic [N*TW-1:0] ea; bit ev, eo; string rq;
        ea = q_allow.pop_front(); ev = q_viol.pop_front();
        eo = q_voff.pop_front(); rq = q_req.pop_front();
        n_vec++;
        if (allow_at !== ea || viol !== ev) begin
          n_bad++;
          $display("FAIL %s: allow_at=%h viol=%b expected allow_at=%h viol=%b", rq, allow_at, viol, ea, ev);
        end
        n_vec++;
        if (allow_off !== '0 || viol_off !== eo) begin
          n_bad++;
          $display("FAIL R9 (%s): disabled allow_at=%h viol=%b expected allow_at=0 viol=%b", rq, allow_off, viol_off, eo);
        end
      end
    end
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_allow[i] = '0;
      for (int k = 0; k < X; k++) m_hist[i][k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, "R7 reset state");
    // R2/R3/R10: tight burst on rank 0, enforced once history is full
    step(1, 0, 10, "R2 fill");
    step(1, 0, 12, "R2 fill");
    step(1, 0, 14, "R2 fill");
    step(1, 0, 16, "R3 R10 enforce at full history");
    // R5: close activate is flagged, still stored and moves the allowed time
    step(1, 0, 18, "R5 violation accepted");
    step(0, 0, 0, "R5 single-cycle pulse");
    // R4: late activate leaves the allowed time alone
    step(1, 0, 100, "R4 outside window hold");
    // R1: other ranks untouched; spread activates on rank 2
    step(1, 2, 5, "R1 isolation");
    step(1, 2, 40, "R4 spread");
    step(1, 2, 80, "R4 spread");
    step(1, 2, 120, "R4 spread full");
    step(1, 2, 125, "R4 spread no enforce");
    // R6: zero timestamps count as empty
    step(1, 1, 0, "R6 zero entry");
    step(1, 1, 1, "R6 zero entry");
    step(1, 1, 2, "R6 zero entry");
    step(1, 1, 3, "R6 oldest zero no enforce");
    step(1, 1, 4, "R6 R3 enforce past zero");
    // R8: out-of-range rank
    step(1, 3, 101, "R8 bad rank ignored");
    step(0, 0, 0, "R8 state after bad rank");
    step(1, 0, 105, "R1 R5 rank0 after others");
    step(0, 0, 0, "R10 idle");
    step(0, 0, 0, "R10 idle");
    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule